// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block is the receive half of a descriptor-chained DMA. Received frames arrive as a byte stream with a last-byte marker. Each frame is held whole in a local frame store. Once the frame is complete, the engine claims the current descriptor from a ring in system memory. It copies the frame into that descriptor's buffer, then writes back a status word that carries the frame length and error flags. Writing that word hands the descriptor back to software. The engine then reaches the next descriptor through the next-pointer word of the one it has just finished.

Software builds the ring and sets the ownership flag on each free descriptor. It places the address of the first descriptor on `ring_base` and raises `dma_en`. Frames are only taken in while `rx_en` is high.

The byte stream is valid/ready. A byte moves on a cycle where `in_valid` and `in_ready` are both high. A producer holds `in_data` and `in_last` while `in_ready` is low. `in_ready` stays low in two cases: while `rx_en` is low, and while a complete frame waits to be written out.

The memory port works as follows:
- A request is offered on `mem_req_valid`. It is taken on a cycle where `mem_req_ready` is high, and it must be held unchanged until then.
- A write completes at the handshake.
- A read is answered later by a single `mem_rsp_valid` pulse. The engine keeps at most one read outstanding.

Top module: `rx_ring_writeback`

## Requirements
- R1: Frame byte k lands at byte address buffer+k, packed little-endian into 32-bit words (byte k in lane k mod 4). Only the lanes that hold stored bytes have their bit in `mem_req_strb` set. The buffer address is word-aligned.
- R2: The written-back status word has bit 31 (owner) cleared and bit 30 clear. Bits 29:16 hold the full received frame length, saturating at 16383. Bits 15:2 are zero.
- R3: A descriptor is four words: status at +0, control at +4 (usable buffer size in bits 13:0), buffer address at +8, next-descriptor address at +12. After its writeback the engine moves to the address read from +12.
- R4: The number of bytes stored is min(frame length, buffer size, CAP_BYTES). No byte past that count is written.
- R5: Status bit 1 (runt) is set when the frame length is below RUNT_LIMIT (64).
- R6: Status bit 0 (truncated) is set when the frame length exceeds the number of bytes stored.
- R7: If a fetched status word has bit 31 clear, nothing is written. The same descriptor is polled again and `cur_desc` does not move.
- R8: No memory request is made for a frame until its last byte has been accepted. While `dma_en` is low, no descriptor is fetched.
- R9: While `dma_en` is low, `cur_desc` loads `ring_base`. Otherwise it shows the address of the descriptor being processed.
- R10: `in_ready` is low while `rx_en` is low, and while a complete frame waits for writeback. Bytes offered during those times are not taken.
- R11: A memory request not yet accepted keeps `mem_req_valid` high and its address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable for the byte stream |
| dma_en | input | 1 | Ring-walk enable; low reloads the ring start |
| ring_base | input | 32 | Address of the first descriptor |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address, word-aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_req_strb | output | 4 | Byte-lane write enables |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Read data |
| cur_desc | output | 32 | Address of the current descriptor |

## Verification
Two activities can coincide in one cycle: the input stream offering the next frame, and the engine writing back the previous one. The bench sends two frames back to back, so the second frame's bytes sit at a closed `in_ready` while the first frame's words and status go out under a stalling memory. Both buffers must then hold the exact byte patterns. A second case pairs an ownership re-poll with a software rearm of the same descriptor: the engine keeps reading a status word while the bench rewrites it, and the frame must land only after the owner bit is set, with the descriptor's earlier status left untouched until then.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STAT,
    ST_CTL,
    ST_BUF,
    ST_NXT,
    ST_DATA,
    ST_WB
  } rxr_state_t;

  localparam int LEN_W = 14;
endpackage

// File: rtl/rxr_frame_store.sv
module rxr_frame_store #(
  parameter int CAP_BYTES = 2048,
  localparam int CAP_WORDS = CAP_BYTES / 4,
  localparam int IDX_W = $clog2(CAP_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  input  logic                    in_last,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [31:0]             rd_word,
  output logic                    frame_ready,
  output logic [rxr_pkg::LEN_W-1:0] frame_len,
  input  logic                    release_i
);
  localparam logic [rxr_pkg::LEN_W-1:0] CAP_L = rxr_pkg::LEN_W'(CAP_BYTES);
  localparam logic [rxr_pkg::LEN_W-1:0] SAT_L = '1;

  logic [31:0] words [CAP_WORDS];
  logic [rxr_pkg::LEN_W-1:0] cnt;
  logic held;
  logic take;

  assign in_ready    = en && !held;
  assign take        = in_valid && in_ready;
  assign frame_ready = held;
  assign frame_len   = cnt;
  assign rd_word     = words[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      held <= 1'b0;
    end else if (release_i) begin
      cnt  <= '0;
      held <= 1'b0;
    end else if (take) begin
      if (cnt != SAT_L) cnt <= cnt + 1'b1;
      if (in_last) held <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take && (cnt < CAP_L))
      words[cnt[IDX_W+1:2]][{cnt[1:0], 3'b000} +: 8] <= in_data;
  end

  // R10
  count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !release_i) |=> $stable(cnt));
endmodule

// File: rtl/rxr_desc_engine.sv
module rxr_desc_engine
  import rxr_pkg::*;
#(
  parameter int CAP_BYTES  = 2048,
  parameter int RUNT_LIMIT = 64,
  localparam int IDX_W = $clog2(CAP_BYTES / 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_en,
  input  logic [31:0]      ring_base,
  input  logic             frame_ready,
  input  logic [LEN_W-1:0] frame_len,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [31:0]      rd_word,
  output logic             frame_release,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [31:0]      mem_req_addr,
  output logic [31:0]      mem_req_wdata,
  output logic [3:0]       mem_req_strb,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_rdata,
  output logic [31:0]      cur_desc
);
  localparam logic [LEN_W-1:0] CAP_L  = LEN_W'(CAP_BYTES);
  localparam logic [LEN_W-1:0] RUNT_L = LEN_W'(RUNT_LIMIT);

  rxr_state_t       state;
  logic             pend;
  logic [31:0]      cur_q, buf_q, next_q;
  logic [LEN_W-1:0] size_q, store_q;
  logic [LEN_W-3:0] widx_q;

  logic [LEN_W-1:0] lim, store_calc, nwords;
  logic             last_word, hs, rsp;
  logic [31:0]      status_word;

  assign lim        = (frame_len < size_q) ? frame_len : size_q;
  assign store_calc = (lim < CAP_L) ? lim : CAP_L;
  assign nwords     = (store_q + LEN_W'(3)) >> 2;
  assign last_word  = ({2'b00, widx_q} == (nwords - 1'b1));
  assign hs         = mem_req_valid && mem_req_ready;
  assign rsp        = pend && mem_rsp_valid;
  assign rd_idx     = widx_q[IDX_W-1:0];
  assign cur_desc   = cur_q;
  assign frame_release = (state == ST_WB) && mem_req_ready;

  assign status_word = {2'b00, frame_len, 14'd0,
                        (frame_len < RUNT_L), (frame_len > store_q)};

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = cur_q;
    mem_req_wdata = '0;
    mem_req_strb  = 4'hF;
    unique case (state)
      ST_STAT: mem_req_valid = !pend;
      ST_CTL: begin
        mem_req_valid = !pend;
        mem_req_addr  = cur_q + 32'd4;
      end
      ST_BUF: begin
        mem_req_valid = !pend;
        mem_req_addr  = cur_q + 32'd8;
      end
      ST_NXT: begin
        mem_req_valid = !pend;
        mem_req_addr  = cur_q + 32'd12;
      end
      ST_DATA: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = buf_q + {18'd0, widx_q, 2'b00};
        mem_req_wdata = rd_word;
        if (last_word) begin
          case (store_q[1:0])
            2'd1:    mem_req_strb = 4'b0001;
            2'd2:    mem_req_strb = 4'b0011;
            2'd3:    mem_req_strb = 4'b0111;
            default: mem_req_strb = 4'b1111;
          endcase
        end
      end
      ST_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_wdata = status_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pend    <= 1'b0;
      cur_q   <= '0;
      buf_q   <= '0;
      next_q  <= '0;
      size_q  <= '0;
      store_q <= '0;
      widx_q  <= '0;
    end else begin
      if (hs && !mem_req_write) pend <= 1'b1;
      if (rsp) pend <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (!dma_en) cur_q <= ring_base;
          else if (frame_ready) state <= ST_STAT;
        end
        ST_STAT: if (rsp) state <= mem_rsp_rdata[31] ? ST_CTL : ST_IDLE;
        ST_CTL: if (rsp) begin
          size_q <= mem_rsp_rdata[LEN_W-1:0];
          state  <= ST_BUF;
        end
        ST_BUF: if (rsp) begin
          buf_q <= mem_rsp_rdata;
          state <= ST_NXT;
        end
        ST_NXT: if (rsp) begin
          next_q  <= mem_rsp_rdata;
          store_q <= store_calc;
          widx_q  <= '0;
          state   <= (store_calc == '0) ? ST_WB : ST_DATA;
        end
        ST_DATA: if (hs) begin
          if (last_word) state <= ST_WB;
          else widx_q <= widx_q + 1'b1;
        end
        ST_WB: if (hs) begin
          cur_q <= next_q;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  data_in_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> ({widx_q, 2'b00} < store_q) && (store_q <= size_q));
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));
  // R7
  own_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STAT && rsp && !mem_rsp_rdata[31]) |=> (state == ST_IDLE) && $stable(cur_q));
  // R8
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !dma_en) |=> (state == ST_IDLE));
  // R8
  release_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_release |-> frame_ready);
endmodule

// File: rtl/rx_ring_writeback.sv
module rx_ring_writeback #(
  parameter int CAP_BYTES  = 2048,
  parameter int RUNT_LIMIT = 64,
  localparam int IDX_W = $clog2(CAP_BYTES / 4)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        dma_en,
  input  logic [31:0] ring_base,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  output logic [3:0]  mem_req_strb,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_rdata,
  output logic [31:0] cur_desc
);
  logic [IDX_W-1:0]             rd_idx;
  logic [31:0]                  rd_word;
  logic                         frame_ready, frame_release;
  logic [rxr_pkg::LEN_W-1:0]    frame_len;

  rxr_frame_store #(.CAP_BYTES(CAP_BYTES)) store_i (
    .clk(clk), .rst_n(rst_n), .en(rx_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .rd_idx(rd_idx), .rd_word(rd_word),
    .frame_ready(frame_ready), .frame_len(frame_len), .release_i(frame_release)
  );

  rxr_desc_engine #(.CAP_BYTES(CAP_BYTES), .RUNT_LIMIT(RUNT_LIMIT)) eng_i (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .ring_base(ring_base),
    .frame_ready(frame_ready), .frame_len(frame_len),
    .rd_idx(rd_idx), .rd_word(rd_word), .frame_release(frame_release),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_strb(mem_req_strb),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .cur_desc(cur_desc)
  );
endmodule

// File: tb/rx_ring_writeback_tb_top.sv
`timescale 1ns/1ps
module rx_ring_writeback_tb_top;
  localparam int CAP  = 128;
  localparam int BASE = 32'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, dma_en = 1'b0;
  logic [31:0] ring_base = BASE;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic mem_req_valid, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0] mem_req_strb;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic [31:0] cur_desc;
  logic mem_req_ready;

  logic [31:0] mem [0:1023];
  logic [31:0] cyc = '0;
  logic host_we = 1'b0;
  logic [31:0] host_addr = '0, host_wdata = '0;
  logic prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  int proto_err = 0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign mem_req_ready = (cyc[1:0] != 2'd3);

  rx_ring_writeback #(.CAP_BYTES(CAP), .RUNT_LIMIT(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dma_en(dma_en), .ring_base(ring_base),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_strb(mem_req_strb),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata), .cur_desc(cur_desc)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (host_we) mem[host_addr[11:2]] <= host_wdata;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        for (int b = 0; b < 4; b++)
          if (mem_req_strb[b]) mem[mem_req_addr[11:2]][8*b +: 8] <= mem_req_wdata[8*b +: 8];
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[11:2]];
      end
    end
    if (rst_n && prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) proto_err++;
    prev_stall <= rst_n && mem_req_valid && !mem_req_ready;
    prev_addr  <= mem_req_addr;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int daddr(input int d); return BASE + 16*d; endfunction
  function automatic int baddr(input int d); return 32'h400 + 32'h200*d; endfunction
  function automatic logic [7:0] pat(input int seed, input int k); return 8'((seed + k*3) & 255); endfunction
  function automatic logic [7:0] rdbyte(input int a); return mem[a>>2][(a&3)*8 +: 8]; endfunction

  task automatic hwr(input int a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rearm(input int d, input int size);
    for (int w = 0; w < 40; w++) hwr(baddr(d) + 4*w, 32'hEEEEEEEE);
    hwr(daddr(d) + 4, size);
    hwr(daddr(d), 32'h8000_0000);
  endtask

  task automatic send_frame(input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pat(seed, k); in_last = (k == len-1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_done(input int d);
    int n;
    n = 0;
    while (mem[daddr(d)>>2][31] && n < 3000) begin @(negedge clk); n++; end
    chk(n < 3000, "R2 writeback timeout", n, 3000);
  endtask

  task automatic check_frame(input int d, input int len, input int size, input int seed);
    int stored, errs, first_k;
    logic [31:0] exp;
    stored = len;
    if (size < stored) stored = size;
    if (CAP < stored) stored = CAP;
    exp = (len << 16) | ((len < 64) ? 2 : 0) | ((len > stored) ? 1 : 0);
    // R2 R5 R6: owner clear, length, runt and truncation flags
    chk(mem[daddr(d)>>2] == exp, "R2/R5/R6 status word", mem[daddr(d)>>2], exp);
    errs = 0; first_k = 0;
    for (int k = 0; k < stored; k++)
      if (rdbyte(baddr(d)+k) != pat(seed, k)) begin
        if (errs == 0) first_k = k;
        errs++;
      end
    // R1: byte placement
    chk(errs == 0, "R1 frame data", rdbyte(baddr(d)+first_k), pat(seed, first_k));
    // R4: nothing beyond stored count
    chk(rdbyte(baddr(d)+stored) == 8'hEE, "R4 no overrun", rdbyte(baddr(d)+stored), 8'hEE);
    // R3: follows the next word
    chk(cur_desc == daddr((d+1)%3), "R3 next descriptor", cur_desc, daddr((d+1)%3));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lens[12]  = '{1, 3, 4, 5, 63, 64, 65, 99, 100, 101, 128, 150};
    int sizes[12] = '{100, 100, 100, 100, 100, 100, 100, 100, 100, 100, 200, 200};
    int d;
    logic [31:0] old;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      hwr(daddr(i) + 8, baddr(i));
      hwr(daddr(i) + 12, daddr((i+1)%3));
    end
    // reset state
    chk(in_ready == 1'b0, "R10 in_ready low with receiver off", in_ready, 0);
    chk(mem_req_valid == 1'b0, "R8 no request after reset", mem_req_valid, 0);
    chk(cur_desc == BASE, "R9 ring start loaded", cur_desc, BASE);

    rearm(0, 100);
    rx_en = 1'b1;
    send_frame(10, 1);
    repeat (40) @(negedge clk);
    chk(mem[daddr(0)>>2] == 32'h8000_0000, "R8 no fetch with dma off", mem[daddr(0)>>2], 32'h8000_0000);
    chk(in_ready == 1'b0, "R10 held frame blocks input", in_ready, 0);
    dma_en = 1'b1;
    wait_done(0);
    check_frame(0, 10, 100, 1);
    d = 1;

    for (int i = 0; i < 12; i++) begin
      rearm(d, sizes[i]);
      send_frame(lens[i], 7 + i);
      wait_done(d);
      check_frame(d, lens[i], sizes[i], 7 + i);
      d = (d + 1) % 3;
    end

    // R7: descriptor still owned by software
    old = mem[daddr(d)>>2];
    send_frame(20, 85);
    repeat (60) @(negedge clk);
    chk(mem[daddr(d)>>2] == old, "R7 unowned descriptor untouched", mem[daddr(d)>>2], old);
    chk(cur_desc == daddr(d), "R7 pointer stays on unowned descriptor", cur_desc, daddr(d));
    rearm(d, 100);
    wait_done(d);
    check_frame(d, 20, 100, 85);
    d = (d + 1) % 3;

    // R10: back-to-back frames, second waits while first is written
    rearm(d, 100);
    rearm((d+1)%3, 100);
    send_frame(70, 9);
    send_frame(30, 51);
    wait_done(d);
    check_frame(d, 70, 100, 9);
    d = (d + 1) % 3;
    wait_done(d);
    check_frame(d, 30, 100, 51);
    d = (d + 1) % 3;

    // R10: bytes offered with receiver off are not taken
    rx_en = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_last = 1'b1; in_data = 8'hAB;
    repeat (10) @(negedge clk);
    chk(in_ready == 1'b0, "R10 in_ready low when disabled", in_ready, 0);
    in_valid = 1'b0; in_last = 1'b0;
    rearm(d, 100);
    rx_en = 1'b1;
    send_frame(30, 113);
    wait_done(d);
    check_frame(d, 30, 100, 113);

    // R9: dropping dma_en reloads ring start
    dma_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(cur_desc == BASE, "R9 reload on dma off", cur_desc, BASE);
    // R11: request stability seen by memory model
    chk(proto_err == 0, "R11 request held until ready", proto_err, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule